// File: doc/BRIEF.md
# External Bus Zone Interface Controller

This block connects a CPU-side memory request port to an asynchronous external bus with a 16-bit data path and a 19-bit address. It takes a 22-bit word address and maps it to one of five external zones. Two pairs of zones share one physical active-low select each, and the fifth zone has its own select. The topmost zone takes part in decode only when the processor mode is set. That mode is the OR of a board-level pin and a mode bit that a control register outside the block supplies, where it sits at bit 8.

Each access runs through three timed phases. In the setup phase the select is low and both strobes are high. In the active phase the read or write strobe is low. In the hold phase the strobe is released and the select stays low. Every zone has its own phase lengths. Each zone can also let an external ready line stretch the active phase. A one-cycle done pulse ends every request. An address outside all enabled zones produces no bus activity and completes at once with an error flag.

Top module: `ext_zone_ctrl`

## Requirements
- R1: Word addresses map as follows: 0x002000–0x003FFF is zone 0 and 0x004000–0x005FFF is zone 1, both on `cs01_no`. 0x080000–0x0FFFFF is zone 2 on `cs2_no`. 0x100000–0x17FFFF is zone 6 and 0x3FC000–0x3FFFFF is zone 7, both on `cs67_no`. At most one select is low at any time, and only from the first setup cycle through the last hold cycle.
- R2: Zone 7 is decoded only while `mode_pin_i | mode_bit_i` is 1. Zone 6 addresses always reach `cs67_no`.
- R3: An address in no enabled zone drives no select and no strobe. `done_o` and `dec_err_o` are both 1 in the cycle after acceptance, and `rdata_o` is 0 in that cycle.
- R4: Per-zone configuration is 8 bits, with zone index z = 0,1,2,3,4 for zones 0,1,2,6,7 at `zone_cfg_i[8z+7:8z]`. Bits [1:0] give the setup length S, from 0 to 3. The setup phase lasts S cycles, with the select low and `rd_no`/`wr_no` high.
- R5: Bits [4:2] give the active count A. The active phase lasts A+1 cycles. In it `rd_no` is low for a read (`we_i`=0), `wr_no` is low for a write, and `rnw_o` is 0 only for a write access.
- R6: When bit 7 is 1, the active phase extends past its counted cycles while `ready_i` is low. When bit 7 is 0, `ready_i` has no effect.
- R7: Bits [6:5] give the hold length H, from 0 to 3. The hold phase lasts H cycles, with the select low and both strobes high.
- R8: `done_o` is high for exactly the one cycle after the hold phase. A read returns on `rdata_o` the `xd_i` value present in the last active cycle. A write leaves `rdata_o` unchanged.
- R9: For a write, `xd_oe_o` is 1 and `xd_o` carries the write data from the first setup cycle to the last hold cycle. Otherwise `xd_oe_o` is 0.
- R10: `xa_o` equals bits [18:0] of the accepted address and stays stable for the whole access.
- R11: Changes on `req_i`, `addr_i`, `wdata_i` and `zone_cfg_i` after acceptance have no effect on the running access. A new request is taken only after `done_o` has pulsed.
- R12: After reset all selects and strobes are high, `rnw_o` is 1, and `xd_oe_o`, `done_o` and `dec_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 22 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| dec_err_o | output | 1 | Decode miss, valid with done |
| mode_pin_i | input | 1 | Board mode pin |
| mode_bit_i | input | 1 | Mode bit from the control register (bit 8) |
| zone_cfg_i | input | 40 | Five 8-bit zone timing configurations |
| ready_i | input | 1 | External ready |
| xa_o | output | 19 | External address |
| xd_o | output | 16 | External write data |
| xd_i | input | 16 | External read data |
| xd_oe_o | output | 1 | Data bus drive enable |
| cs01_no | output | 1 | Select for zones 0 and 1, active low |
| cs2_no | output | 1 | Select for zone 2, active low |
| cs67_no | output | 1 | Select for zones 6 and 7, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| rnw_o | output | 1 | Direction, 0 during a write access |

## Verification
Counting from the clock edge that accepts a request as cycle 0, setup occupies cycles 1..S and active occupies S+1..S+A+1+W, where W is the number of ready wait cycles. Hold follows for H cycles, and done falls in cycle S+A+W+H+2. A decode miss shows done in cycle 1. The bench derives these windows from the zone's configuration and drives `ready_i` and `xd_i` per cycle. It samples each cycle on the falling edge, so every select, strobe and data output is checked in the cycle it is due. Read data is driven to its valid value only in the last active cycle, which shows whether the capture lands on exactly that cycle.

// File: rtl/ezc_pkg.sv
package ezc_pkg;
  localparam int AW       = 22;
  localparam int NZ       = 5;
  localparam int NCS      = 3;
  localparam int TOP_ZONE = 4;
  localparam int CNT_W    = 3;

  typedef struct packed {
    logic       rdy_en;
    logic [1:0] hold;
    logic [2:0] act;
    logic [1:0] setup;
  } zcfg_t;

  localparam int CFG_W = $bits(zcfg_t);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ACT, S_HOLD, S_DONE
  } seq_st_t;

  localparam logic [AW-1:0] ZBASE [NZ] = '{22'h002000, 22'h004000, 22'h080000,
                                           22'h100000, 22'h3FC000};
  localparam logic [AW-1:0] ZMASK [NZ] = '{22'h001FFF, 22'h001FFF, 22'h07FFFF,
                                           22'h07FFFF, 22'h003FFF};
  // physical select index per zone
  localparam int ZCS [NZ] = '{0, 0, 1, 2, 2};
endpackage

// File: rtl/ezc_zone_decode.sv
module ezc_zone_decode
  import ezc_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic          mode_i,
  output logic [NZ-1:0] hit_o,
  output logic          miss_o
);
  for (genvar z = 0; z < NZ; z++) begin : g_zone
    logic in_range;
    assign in_range = (addr_i & ~ZMASK[z]) == ZBASE[z];
    if (z == TOP_ZONE) begin : g_gated
      assign hit_o[z] = in_range & mode_i;
    end else begin : g_always
      assign hit_o[z] = in_range;
    end
  end

  assign miss_o = ~|hit_o;
endmodule

// File: rtl/ezc_cs_merge.sv
module ezc_cs_merge
  import ezc_pkg::*;
(
  input  logic [NZ-1:0]  zone_i,
  input  logic           busy_i,
  output logic [NCS-1:0] cs_no
);
  for (genvar c = 0; c < NCS; c++) begin : g_cs
    logic [NZ-1:0] grp;
    for (genvar z = 0; z < NZ; z++) begin : g_member
      assign grp[z] = (ZCS[z] == c) ? zone_i[z] : 1'b0;
    end
    // AND of per-zone active-low selects
    assign cs_no[c] = ~(busy_i & |grp);
  end
endmodule

// File: rtl/ezc_seq.sv
module ezc_seq
  import ezc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int XAW = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [XAW-1:0]    addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NZ-1:0]     hit_i,
  input  logic              miss_i,
  input  logic [NZ*CFG_W-1:0] cfg_i,
  input  logic              ready_i,
  input  logic [DW-1:0]     xd_i,
  output logic [NZ-1:0]     zone_o,
  output logic              busy_o,
  output logic              strobe_o,
  output logic              we_o,
  output logic [XAW-1:0]    xa_o,
  output logic [DW-1:0]     wdata_o,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o,
  output logic              err_o
);
  seq_st_t            st_q;
  logic [CNT_W-1:0]   cnt_q;
  zcfg_t              cfg_q, sel_cfg;
  logic [NZ-1:0]      zone_q;
  logic               we_q, err_q;
  logic [XAW-1:0]     addr_q;
  logic [DW-1:0]      wdata_q, rdata_q;

  always_comb begin
    sel_cfg = '0;
    for (int z = 0; z < NZ; z++)
      if (hit_i[z]) sel_cfg = sel_cfg | zcfg_t'(cfg_i[z*CFG_W +: CFG_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      cfg_q   <= '0;
      zone_q  <= '0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          we_q    <= we_i;
          zone_q  <= hit_i;
          cfg_q   <= sel_cfg;
          err_q   <= miss_i;
          if (miss_i) begin
            rdata_q <= '0;
            st_q    <= S_DONE;
          end else if (sel_cfg.setup != '0) begin
            cnt_q <= CNT_W'(sel_cfg.setup - 2'd1);
            st_q  <= S_SETUP;
          end else begin
            cnt_q <= sel_cfg.act;
            st_q  <= S_ACT;
          end
        end
        S_SETUP: begin
          if (cnt_q == '0) begin
            cnt_q <= cfg_q.act;
            st_q  <= S_ACT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_ACT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!cfg_q.rdy_en || ready_i) begin
            if (!we_q) rdata_q <= xd_i;
            if (cfg_q.hold != '0) begin
              cnt_q <= CNT_W'(cfg_q.hold - 2'd1);
              st_q  <= S_HOLD;
            end else begin
              st_q <= S_DONE;
            end
          end
        end
        S_HOLD: begin
          if (cnt_q == '0) st_q <= S_DONE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q == S_SETUP) || (st_q == S_ACT) || (st_q == S_HOLD);
  assign strobe_o = (st_q == S_ACT);
  assign zone_o   = zone_q;
  assign we_o     = we_q;
  assign xa_o     = addr_q;
  assign wdata_o  = wdata_q;
  assign rdata_o  = rdata_q;
  assign done_o   = (st_q == S_DONE);
  assign err_o    = (st_q == S_DONE) && err_q;
endmodule

// File: rtl/ext_zone_ctrl.sv
module ext_zone_ctrl
  import ezc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int XAW = 19
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                done_o,
  output logic                dec_err_o,
  input  logic                mode_pin_i,
  input  logic                mode_bit_i,
  input  logic [NZ*CFG_W-1:0] zone_cfg_i,
  input  logic                ready_i,
  output logic [XAW-1:0]      xa_o,
  output logic [DW-1:0]       xd_o,
  input  logic [DW-1:0]       xd_i,
  output logic                xd_oe_o,
  output logic                cs01_no,
  output logic                cs2_no,
  output logic                cs67_no,
  output logic                rd_no,
  output logic                wr_no,
  output logic                rnw_o
);
  logic [NZ-1:0]  hit, zone;
  logic           miss, busy, strobe, we;
  logic [NCS-1:0] cs_n;

  ezc_zone_decode u_dec (
    .addr_i (addr_i),
    .mode_i (mode_pin_i | mode_bit_i),
    .hit_o  (hit),
    .miss_o (miss)
  );

  ezc_seq #(.DW(DW), .XAW(XAW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i[XAW-1:0]),
    .wdata_i  (wdata_i),
    .hit_i    (hit),
    .miss_i   (miss),
    .cfg_i    (zone_cfg_i),
    .ready_i  (ready_i),
    .xd_i     (xd_i),
    .zone_o   (zone),
    .busy_o   (busy),
    .strobe_o (strobe),
    .we_o     (we),
    .xa_o     (xa_o),
    .wdata_o  (xd_o),
    .rdata_o  (rdata_o),
    .done_o   (done_o),
    .err_o    (dec_err_o)
  );

  ezc_cs_merge u_cs (
    .zone_i (zone),
    .busy_i (busy),
    .cs_no  (cs_n)
  );

  assign cs01_no = cs_n[0];
  assign cs2_no  = cs_n[1];
  assign cs67_no = cs_n[2];
  assign rd_no   = ~(strobe & ~we);
  assign wr_no   = ~(strobe & we);
  assign rnw_o   = ~(busy & we);
  assign xd_oe_o = busy & we;
endmodule

// File: rtl/ext_zone_ctrl_chk.sv
module ext_zone_ctrl_chk #(
  parameter int DW  = 16,
  parameter int XAW = 19
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cs01_no,
  input logic           cs2_no,
  input logic           cs67_no,
  input logic           rd_no,
  input logic           wr_no,
  input logic           rnw_o,
  input logic           xd_oe_o,
  input logic           done_o,
  input logic           dec_err_o,
  input logic [DW-1:0]  rdata_o,
  input logic [XAW-1:0] xa_o
);
  logic any_cs;
  assign any_cs = ~(cs01_no & cs2_no & cs67_no);

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~cs01_no, ~cs2_no, ~cs67_no}) <= 1); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(~rd_no && ~wr_no)); // R5
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~rd_no || ~wr_no) |-> any_cs); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_o |-> (done_o && !any_cs && rdata_o == '0)); // R3
  AST_DONE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !any_cs); // R8
  AST_OE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xd_oe_o |-> (!rnw_o && any_cs && rd_no)); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cs |=> (!any_cs || $stable(xa_o))); // R10
endmodule

bind ext_zone_ctrl ext_zone_ctrl_chk #(.DW(DW), .XAW(XAW)) u_chk (.*);

// File: tb/ext_zone_ctrl_test.sv
module ext_zone_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic [15:0] wdata_i = '0, xd_i = '0;
  logic        mode_pin_i = 1'b0, mode_bit_i = 1'b0, ready_i = 1'b0;
  logic [39:0] zone_cfg_i = '0;
  logic [15:0] rdata_o, xd_o;
  logic [18:0] xa_o;
  logic done_o, dec_err_o, xd_oe_o, cs01_no, cs2_no, cs67_no, rd_no, wr_no, rnw_o;

  int n_tests = 0, n_fail = 0;
  logic [15:0] exp_rdata = '0;
  int cs_s[5], cs_a[5], cs_h[5], cs_r[5];

  always #2 clk_i = ~clk_i;

  ext_zone_ctrl uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic int zone_of(input logic [21:0] a);
    int v = int'(a);
    bit md = mode_pin_i | mode_bit_i;
    if (v >= 'h2000 && v < 'h4000) return 0;
    if (v >= 'h4000 && v < 'h6000) return 1;
    if (v >= 'h80000 && v < 'h100000) return 2;
    if (v >= 'h100000 && v < 'h180000) return 3;
    if (md && v >= 'h3FC000) return 4;
    return -1;
  endfunction

  function automatic logic [39:0] pack_cfg();
    logic [39:0] p = '0;
    for (int z = 0; z < 5; z++)
      p[z*8 +: 8] = {cs_r[z][0], cs_h[z][1:0], cs_a[z][2:0], cs_s[z][1:0]};
    return p;
  endfunction

  // ctl = {cs01,cs2,cs67,rd,wr,rnw,oe,done}
  function automatic logic [7:0] ctl_now();
    return {cs01_no, cs2_no, cs67_no, rd_no, wr_no, rnw_o, xd_oe_o, done_o};
  endfunction

  task automatic idle_check(input string tag);
    chk(ctl_now() == 8'b1111_1100 && !dec_err_o, tag, {23'd0, dec_err_o, ctl_now()},
        32'hFC);
  endtask

  task automatic access(input logic [21:0] a, input bit w, input logic [15:0] d,
                        input int waits, input bit poke, input string ztag);
    int z, s, ac, h, re, last, tot, grp;
    logic [39:0] cfg_keep;
    logic [15:0] rv;
    @(negedge clk_i);
    idle_check("R12");
    rv = d ^ 16'h5A5A;
    z = zone_of(a);
    addr_i = a; we_i = w; wdata_i = d; req_i = 1'b1; ready_i = 1'b0; xd_i = ~rv;
    cfg_keep = zone_cfg_i;
    @(negedge clk_i);
    req_i = poke; addr_i = a ^ 22'h3FFFFF; wdata_i = ~d;
    if (poke) zone_cfg_i = ~cfg_keep;
    if (z < 0) begin
      req_i = 1'b0;
      exp_rdata = '0;
      chk(ctl_now() == 8'b1111_1101, "R3", {24'd0, ctl_now()}, 32'hFD);
      chk(dec_err_o && rdata_o == 16'h0, "R3", {15'd0, dec_err_o, rdata_o}, 32'h10000);
      return;
    end
    s = cs_s[z]; ac = cs_a[z]; h = cs_h[z]; re = cs_r[z];
    grp = (z < 2) ? 0 : (z == 2) ? 1 : 2;
    last = s + ac + 1 + (re ? waits : 0);
    tot  = last + h + 1;
    for (int k = 1; k <= tot; k++) begin
      logic [7:0] e;
      string tag;
      bit in_acc = (k <= last + h);
      bit in_act = (k > s) && (k <= last);
      ready_i = re ? (k >= last) : 1'b0;
      xd_i = (k == last) ? rv : (~rv ^ 16'(k));
      e[7] = !(in_acc && grp == 0);
      e[6] = !(in_acc && grp == 1);
      e[5] = !(in_acc && grp == 2);
      e[4] = !(in_act && !w);
      e[3] = !(in_act && w);
      e[2] = !(in_acc && w);
      e[1] = in_acc && w;
      e[0] = (k == tot);
      if (poke)                 tag = "R11";
      else if (k <= s)          tag = "R4";
      else if (k <= s + ac + 1) tag = "R5";
      else if (k <= last)       tag = "R6";
      else if (k <= last + h)   tag = "R7";
      else                      tag = "R8";
      #0.1;
      chk(ctl_now() == e, tag, {24'd0, ctl_now()}, {24'd0, e});
      chk(ctl_now()[7:5] == e[7:5], ztag, {29'd0, ctl_now()[7:5]}, {29'd0, e[7:5]});
      chk(xa_o == a[18:0], "R10", {13'd0, xa_o}, {13'd0, a[18:0]});
      if (w && in_acc) chk(xd_o == d, "R9", {16'd0, xd_o}, {16'd0, d});
      if (k == tot) begin
        if (!w) exp_rdata = rv;
        chk(rdata_o == exp_rdata, "R8", {16'd0, rdata_o}, {16'd0, exp_rdata});
        chk(!dec_err_o, "R3", {31'd0, dec_err_o}, 32'd0);
        req_i = 1'b0;
        zone_cfg_i = cfg_keep;
      end else begin
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cs_s = '{1, 3, 0, 2, 1};
    cs_a = '{0, 7, 2, 1, 3};
    cs_h = '{0, 3, 1, 2, 1};
    cs_r = '{0, 0, 1, 1, 0};
    zone_cfg_i = pack_cfg();
    repeat (3) @(negedge clk_i);
    idle_check("R12");
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_check("R12");

    access(22'h002345, 1'b0, 16'h1234, 0, 1'b0, "R1");   // zone 0 read
    access(22'h005FFF, 1'b1, 16'hBEEF, 0, 1'b0, "R1");   // zone 1 write, long phases
    access(22'h0A0001, 1'b0, 16'h0F0F, 3, 1'b0, "R1");   // zone 2 read, 3 ready waits
    access(22'h17FFFF, 1'b1, 16'hC001, 0, 1'b0, "R2");   // zone 6 write, mode 0
    access(22'h3FC010, 1'b0, 16'h7777, 0, 1'b0, "R2");   // zone 7 disabled -> miss
    mode_pin_i = 1'b1;
    access(22'h3FFFFE, 1'b0, 16'h2222, 0, 1'b0, "R2");   // zone 7 via pin
    mode_pin_i = 1'b0; mode_bit_i = 1'b1;
    access(22'h3FC000, 1'b1, 16'h3333, 0, 1'b0, "R2");   // zone 7 via mode bit
    mode_bit_i = 1'b0;
    access(22'h000100, 1'b0, 16'h4444, 0, 1'b0, "R3");   // below zone 0
    access(22'h006000, 1'b1, 16'h4545, 0, 1'b0, "R3");   // gap after zone 1
    access(22'h180000, 1'b0, 16'h4646, 0, 1'b0, "R3");   // gap after zone 6
    cs_r[0] = 1; cs_s[0] = 0; cs_h[0] = 3;
    zone_cfg_i = pack_cfg();
    access(22'h003FFF, 1'b0, 16'h5555, 2, 1'b0, "R1");   // zone 0 new cfg, waits
    cs_r[0] = 0;
    zone_cfg_i = pack_cfg();
    access(22'h002000, 1'b0, 16'h6666, 4, 1'b0, "R6");   // ready ignored, low
    access(22'h0FFFFF, 1'b0, 16'h8888, 1, 1'b1, "R11");  // input churn while busy
    access(22'h100000, 1'b1, 16'h9999, 2, 1'b1, "R11");
    access(22'h080000, 1'b0, 16'hAAAA, 0, 1'b0, "R1");
    @(negedge clk_i);
    idle_check("R12");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule